// File: doc/BRIEF.md
# Clocked Serial Port with Buffered Block Transfer

This block is an 8-bit clock-synchronous serial port with a data output, a data input, a serial clock and an optional active-low chip-select input. It moves a whole block of bytes without help from a processor. A 32-entry byte buffer holds the outgoing data. After a start pulse, the port reads slot 0, shifts it out and at the same time shifts in a byte. It writes the received byte back into the same slot, then moves on to the next slot. It stops after the programmed number of bytes and raises a sticky completion flag.

The port can generate the serial clock itself (master) or follow a clock from outside (slave). Software can choose which bit goes first. In chip-select mode, a high level on the select input holds off the transfer and puts the data output (and the clock output in master mode) into high impedance. If the select input rises while a byte is being shifted, the transfer is abandoned and a sticky error flag is raised.

The controller is a four-state machine:
- **ST_IDLE**: waiting. A start pulse moves it to ST_LOAD and resets the slot address.
- **ST_LOAD**: fetches the current slot into the transmit register. It moves to ST_SHIFT once the port is enabled, which means chip-select mode is off or the select input is low.
- **ST_SHIFT**: runs eight clock periods. It returns to ST_IDLE with the error flag set if the port is disabled mid-frame. After the eighth rising edge it moves to ST_STORE.
- **ST_STORE**: writes the received byte. It moves to ST_IDLE with the completion flag set after the last byte, and otherwise advances the address and returns to ST_LOAD.

The mode inputs (`master_mode`, `cs_mode`, `lsb_first`) must be held steady while `busy` is high.

Top module: `csio_block_xfer`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `sck_out` is 1.
- R2: In master mode, `sck_out` is high whenever the port is idle or between frames. Within a frame it has a period of 8 clock cycles, low for 4 and high for 4, and the first edge of a frame is a falling edge.
- R3: With `lsb_first`=0, bit 7 of each buffer byte appears first on `so`, and the first bit received lands in bit 7 of the stored byte.
- R4: With `lsb_first`=1, bit 0 goes out first, and the first bit received lands in bit 0.
- R5: A start pulse while idle makes `busy` high on the next cycle. The port then transfers `count_m1`+1 bytes (1 to 32), slot 0 first. Each received byte replaces the slot its transmitted byte came from, and slots beyond the count are left unchanged.
- R6: `done` rises when `busy` falls after the last byte. It stays 1 until `done_clr` is pulsed.
- R7: In slave mode, `si` is sampled on rising edges of `sck_in`, and `so` changes only after falling edges. The first bit of each byte is on `so` before the first falling edge of that byte.
- R8: With `cs_mode`=1 and `cs_n`=1, `so_oe` and `sck_oe` are 0 and no clock edge is produced. The transfer waits in ST_LOAD until `cs_n` goes low.
- R9: If `cs_n` rises during ST_SHIFT in chip-select mode, the port returns to idle with `err`=1 and `done`=0. The partly shifted byte is not stored, so its slot keeps its old value.
- R10: `err` stays 1 until `err_clr` is pulsed.
- R11: A start pulse while `busy` is 1 is ignored. The byte count latched at the accepted start is kept.
- R12: `sck_oe` is 0 in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that starts a block transfer |
| count_m1 | input | 5 | Number of bytes minus one, latched at start |
| lsb_first | input | 1 | 1 selects least-significant bit first |
| master_mode | input | 1 | 1 makes the port generate the serial clock |
| cs_mode | input | 1 | 1 gates the port with `cs_n` |
| done_clr | input | 1 | Clears the completion flag |
| err_clr | input | 1 | Clears the error flag |
| host_we | input | 1 | Buffer write strobe from the host side |
| host_addr | input | 5 | Buffer slot for host access |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Contents of the slot at `host_addr` |
| sck_in | input | 1 | Serial clock from outside (slave mode) |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Output enable for `sck_out` |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for `so` |
| cs_n | input | 1 | Active-low chip select |
| busy | output | 1 | A block transfer is in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky abort flag |

## Verification
Each kind of internal fault shows up at the ports in a recognisable way:
- A wrong slot address or a write in the wrong state leaves a received byte in the wrong buffer slot. The slot read-back after `done` shows this, at most one frame after the fault.
- A wrong shift direction or an off-by-one bit counter corrupts the very first byte on `so`. The slave model on the bench sees this within one 8-cycle clock period.
- A stuck state-machine transition appears as a missing `done`, or as `busy` that never falls.
- A faulty abort path leaves `err` low, or lets a partly shifted byte overwrite its slot, within a few cycles of the select input rising.

// File: rtl/csio_pkg.sv
package csio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_STORE = 2'd3
    } csio_state_e;
endpackage

// File: rtl/csio_sync.sv
module csio_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= INIT;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= INIT;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/csio_sck_master.sv
module csio_sck_master #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [DIV_W-1:0] div_q;
    logic             sck_q;
    logic             at_end;

    assign at_end = (div_q == DIV_W'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            sck_q <= 1'b1;
        end else if (!run) begin
            div_q <= '0;
            sck_q <= 1'b1;
        end else if (at_end) begin
            div_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Forced high the moment the frame ends, so an abort never leaves it low.
    assign sck     = sck_q | ~run;
    assign fall_ev = run & at_end & sck_q;
    assign rise_ev = run & at_end & ~sck_q;
endmodule

// File: rtl/csio_buffer.sv
module csio_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] eng_rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (host_we) mem[host_addr] <= host_wdata;
        if (eng_we)  mem[eng_addr]  <= eng_wdata;
    end

    assign host_rdata = mem[host_addr];
    assign eng_rdata  = mem[eng_addr];
endmodule

// File: rtl/csio_block_xfer.sv
module csio_block_xfer
    import csio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 32,
    parameter int HALF_PERIOD = 4,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] count_m1,
    input  logic              lsb_first,
    input  logic              master_mode,
    input  logic              cs_mode,
    input  logic              done_clr,
    input  logic              err_clr,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    csio_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q, last_q;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic [CNT_W-1:0]  bit_q;
    logic              done_q, err_q;

    logic [2:0] sync_q;
    logic       sck_s, si_s, cs_s, sck_prev;
    logic       m_run, m_rise, m_fall;
    logic       rise_ev, fall_ev, gate_ok, si_bit, frame_end, at_last;
    logic       eng_we;
    logic [DATA_W-1:0] eng_rdata;

    // Outside-world inputs brought into the clock domain
    csio_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b101)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({sck_in, si, cs_n}),
        .q   (sync_q)
    );
    assign {sck_s, si_s, cs_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b1;
        else        sck_prev <= sck_s;
    end

    assign m_run = (state_q == ST_SHIFT) & master_mode;

    csio_sck_master #(.HALF(HALF_PERIOD)) u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (m_run),
        .sck     (sck_out),
        .rise_ev (m_rise),
        .fall_ev (m_fall)
    );

    csio_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_we     (eng_we),
        .eng_addr   (addr_q),
        .eng_wdata  (rx_q),
        .eng_rdata  (eng_rdata)
    );

    assign rise_ev   = master_mode ? m_rise : (sck_s & ~sck_prev);
    assign fall_ev   = master_mode ? m_fall : (~sck_s & sck_prev);
    assign si_bit    = master_mode ? si : si_s;
    assign gate_ok   = ~cs_mode | ~cs_s;
    assign frame_end = rise_ev & (bit_q == CNT_W'(DATA_W - 1));
    assign at_last   = (addr_q == last_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  if (gate_ok) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (!gate_ok)       state_d = ST_IDLE;
                else if (frame_end) state_d = ST_STORE;
            end
            ST_STORE: state_d = at_last ? ST_IDLE : ST_LOAD;
        endcase
    end

    // Outputs
    always_comb begin
        eng_we = (state_q == ST_STORE);
        busy   = (state_q != ST_IDLE);
        so_oe  = ~(cs_mode & cs_n);
        sck_oe = master_mode & ~(cs_mode & cs_n);
        so     = lsb_first ? tx_q[0] : tx_q[DATA_W-1];
        done   = done_q;
        err    = err_q;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            last_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    addr_q <= '0;
                    last_q <= count_m1;
                end
                ST_LOAD: begin
                    tx_q  <= eng_rdata;
                    bit_q <= '0;
                end
                ST_SHIFT: begin
                    if (rise_ev) begin
                        rx_q  <= lsb_first ? {si_bit, rx_q[DATA_W-1:1]}
                                           : {rx_q[DATA_W-2:0], si_bit};
                        bit_q <= bit_q + 1'b1;
                    end
                    if (fall_ev && bit_q != '0)
                        tx_q <= lsb_first ? {1'b0, tx_q[DATA_W-1:1]}
                                          : {tx_q[DATA_W-2:0], 1'b0};
                end
                ST_STORE: if (!at_last) addr_q <= addr_q + 1'b1;
            endcase
        end
    end

    // Sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (state_q == ST_STORE && at_last) done_q <= 1'b1;
            else if (done_clr)                  done_q <= 1'b0;
            if (state_q == ST_SHIFT && !gate_ok) err_q <= 1'b1;
            else if (err_clr)                    err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/csio_checker.sv
module csio_checker #(
    parameter int HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic done_clr,
    input logic err,
    input logic err_clr,
    input logic sck_out
);
    logic       prev_sck;
    logic [7:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sck <= 1'b1;
            run_len  <= '0;
        end else begin
            prev_sck <= sck_out;
            if (sck_out != prev_sck) run_len <= 8'd1;
            else if (run_len != 8'hFF) run_len <= run_len + 8'd1;
        end
    end

    AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out); // R2
    AST_SCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sck_out && !prev_sck) |-> (run_len == 8'(HALF))); // R2
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy)); // R6
    AST_ABORT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $fell(busy)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err); // R10
endmodule

bind csio_block_xfer csio_checker #(.HALF(HALF_PERIOD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .done_clr (done_clr),
    .err      (err),
    .err_clr  (err_clr),
    .sck_out  (sck_out)
);

// File: tb/sim_csio_block_xfer.sv
module sim_csio_block_xfer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] count_m1 = '0;
    logic       lsb_first = 1'b0, master_mode = 1'b1, cs_mode = 1'b0;
    logic       done_clr = 1'b0, err_clr = 1'b0;
    logic       host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       sck_in = 1'b1, sck_out, sck_oe, si, so, so_oe, cs_n = 1'b1;
    logic       busy, done, err;
    logic       si_m = 1'b0, si_d = 1'b0;

    int nchk = 0, nfail = 0;

    logic [7:0] tx_orig [32];
    logic [7:0] slv_tx  [32];
    logic [7:0] cap     [32];
    int         bidx, nrise, nfall;
    logic       model_en = 1'b0, model_lsb = 1'b0;
    realtime    t_fall0, t_rise0, t_rise1;

    assign si = master_mode ? si_m : si_d;

    csio_block_xfer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .count_m1(count_m1),
        .lsb_first(lsb_first), .master_mode(master_mode), .cs_mode(cs_mode),
        .done_clr(done_clr), .err_clr(err_clr), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so),
        .so_oe(so_oe), .cs_n(cs_n), .busy(busy), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic stream_bit(input int i);
        int pos;
        if (i / 8 >= 32) return 1'b0;
        pos = model_lsb ? (i % 8) : (7 - i % 8);
        return slv_tx[i/8][pos];
    endfunction

    // Slave device model used while the port is master
    always @(posedge sck_out) begin
        if (model_en) begin
            if (nrise == 0) t_rise0 = $realtime;
            if (nrise == 1) t_rise1 = $realtime;
            nrise++;
            if (bidx / 8 < 32) cap[bidx/8][model_lsb ? (bidx % 8) : (7 - bidx % 8)] = so;
            bidx++;
            #1 si_m = stream_bit(bidx);
        end
    end
    always @(negedge sck_out) begin
        if (model_en) begin
            if (nfall == 0) t_fall0 = $realtime;
            nfall++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic slot(input int a, output logic [7:0] d);
        host_addr = 5'(a);
        #1 d = host_rdata;
    endtask

    task automatic fill(input logic lsb);
        for (int i = 0; i < 32; i++) begin
            tx_orig[i] = 8'hA5 ^ 8'(i * 37);
            slv_tx[i]  = 8'h3C + 8'(i * 29);
            cap[i]     = 8'h00;
            host_write(i, tx_orig[i]);
        end
        model_lsb = lsb; bidx = 0; nrise = 0; nfall = 0;
        si_m = stream_bit(0);
        @(negedge clk);
        done_clr = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0; err_clr = 1'b0;
    endtask

    task automatic pulse_start(input int n);
        @(negedge clk);
        start = 1'b1; count_m1 = 5'(n - 1);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int lim, input string req);
        for (int i = 0; i < lim; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk(req, done, 1'b1);
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 err", err, 1'b0);
        chk("R1 sck_out", sck_out, 1'b1);
    endtask

    task automatic t_master(input int n, input logic lsb, input string req);
        logic [7:0] d;
        master_mode = 1'b1; cs_mode = 1'b0; lsb_first = lsb;
        fill(lsb);
        model_en = 1'b1;
        pulse_start(n);
        chk("R5 busy after start", busy, 1'b1);
        wait_done(n * 100 + 50, "R6 done");
        model_en = 1'b0;
        chk("R6 busy low at done", busy, 1'b0);
        chk("R2 sck idle high", sck_out, 1'b1);
        chk("R2 half period", 32'(int'(t_rise0 - t_fall0)), 32'(4 * CLK_PERIOD));
        chk("R2 full period", 32'(int'(t_rise1 - t_rise0)), 32'(8 * CLK_PERIOD));
        for (int i = 0; i < n; i++) begin
            slot(i, d);
            chk({req, " stored slot"}, d, slv_tx[i]);
            chk({req, " sent byte"}, cap[i], tx_orig[i]);
        end
        if (n < 32) begin
            slot(n, d);
            chk("R5 slot past count", d, tx_orig[n]);
        end
        cycles(5);
        chk("R6 done sticky", done, 1'b1);
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
        chk("R6 done cleared", done, 1'b0);
    endtask

    task automatic t_start_ignored;
        logic [7:0] d;
        master_mode = 1'b1; cs_mode = 1'b0; lsb_first = 1'b0;
        fill(1'b0);
        model_en = 1'b1;
        pulse_start(2);
        cycles(20);
        pulse_start(8);
        wait_done(400, "R11 done");
        model_en = 1'b0;
        slot(1, d); chk("R11 slot1", d, slv_tx[1]);
        slot(2, d); chk("R11 slot2 untouched", d, tx_orig[2]);
        cycles(200);
        chk("R11 no restart", busy, 1'b0);
    endtask

    task automatic slave_byte(input int b, input int nbits, output logic [7:0] got);
        got = '0;
        for (int k = 0; k < nbits; k++) begin
            sck_in = 1'b0;
            si_d = slv_tx[b][7-k];
            cycles(8);
            got[7-k] = so;
            sck_in = 1'b1;
            cycles(8);
        end
    endtask

    task automatic t_slave;
        logic [7:0] got, d;
        master_mode = 1'b0; cs_mode = 1'b0; lsb_first = 1'b0;
        fill(1'b0);
        pulse_start(2);
        cycles(4);
        chk("R12 sck_oe slave", sck_oe, 1'b0);
        chk("R7 first bit early", so, tx_orig[0][7]);
        slave_byte(0, 8, got);
        chk("R7 byte0 out", got, tx_orig[0]);
        slave_byte(1, 8, got);
        chk("R7 byte1 out", got, tx_orig[1]);
        wait_done(50, "R7 done");
        slot(0, d); chk("R7 slot0 in", d, slv_tx[0]);
        slot(1, d); chk("R7 slot1 in", d, slv_tx[1]);
    endtask

    task automatic t_cs_master;
        logic [7:0] d;
        master_mode = 1'b1; cs_mode = 1'b1; lsb_first = 1'b0; cs_n = 1'b1;
        fill(1'b0);
        #1;
        chk("R8 sck_oe off", sck_oe, 1'b0);
        chk("R8 so_oe off", so_oe, 1'b0);
        model_en = 1'b1;
        pulse_start(1);
        cycles(30);
        chk("R8 waiting busy", busy, 1'b1);
        chk("R8 no edges", nfall, 0);
        cs_n = 1'b0;
        #1;
        chk("R8 sck_oe on", sck_oe, 1'b1);
        wait_done(200, "R8 done");
        model_en = 1'b0;
        slot(0, d); chk("R8 slot0", d, slv_tx[0]);
        cs_n = 1'b1;
    endtask

    task automatic t_cs_abort;
        logic [7:0] got, d;
        master_mode = 1'b0; cs_mode = 1'b1; lsb_first = 1'b0; cs_n = 1'b1;
        fill(1'b0);
        pulse_start(2);
        cycles(6);
        chk("R8 held in load", busy, 1'b1);
        chk("R8 so_oe off", so_oe, 1'b0);
        cs_n = 1'b0;
        cycles(4);
        chk("R8 so_oe on", so_oe, 1'b1);
        slave_byte(0, 8, got);
        chk("R9 byte0 out", got, tx_orig[0]);
        slave_byte(1, 3, got);
        cs_n = 1'b1;
        #1;
        chk("R8 so_oe off mid", so_oe, 1'b0);
        cycles(6);
        chk("R9 err", err, 1'b1);
        chk("R9 busy", busy, 1'b0);
        chk("R9 no done", done, 1'b0);
        slot(0, d); chk("R9 slot0 stored", d, slv_tx[0]);
        slot(1, d); chk("R9 slot1 kept", d, tx_orig[1]);
        cycles(5);
        chk("R10 err sticky", err, 1'b1);
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        chk("R10 err cleared", err, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        cycles(3);
        t_reset();
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_master(3, 1'b0, "R3");
        t_master(32, 1'b1, "R4");
        t_master(1, 1'b0, "R5");
        t_start_ignored();
        t_slave();
        t_cs_master();
        t_cs_abort();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule